// File: doc/BRIEF.md
# Smart panel command sequencer

This block walks a list of 16-bit command words for a panel that has its own frame memory and turns each one into an action on a simple bus-request interface. That interface feeds a separate engine that owns the panel's pin timing. Command words arrive two at a time, packed into 32-bit words on a valid/ready stream. The list length is given in bytes when the list is started. Each command carries a 3-bit opcode, a command/data select flag and a payload byte. The opcode selects one of these actions: a command or data write, streaming of a programmed number of frame pixels from a second valid/ready stream, a panel read, a wait for vertical sync, nothing, or raising a sticky interrupt status bit.

Software sees three word registers. The status register at address 0 holds two sticky bits, both cleared by writing 1. The panel-read register at address 1 holds the last byte read back and two release flags. A write to the command control register at address 2 breaks a pending vertical-sync wait. After a panel read the sequencer stalls until software sets one of the two release flags. While it waits for vertical sync it stays blocked until a sync pulse arrives or software forces it out.

Top module: `smart_cmd_seq`

## Requirements
- R1: A command word carries its opcode in bits [11:9], the select flag in bit 8 and the payload in bits [7:0]. Opcode 1 issues one bus write with bus_rd=0, bus_a0 equal to bit 8 and bus_wdata equal to the payload.
- R2: The lower halfword of each 32-bit list word runs before the upper halfword. The list holds list_bytes/2 commands. With list_bytes=2, only the lower half of the single word runs and no second word is taken.
- R3: When the last command of a list finishes, busy falls and done is high for exactly one cycle. A start with list_bytes=0 raises done one cycle later and takes no word.
- R4: Opcode 0 issues a bus read with bus_a0 equal to bit 8. The returned byte lands in bits [7:0] of register 1 and the select flag in its bit 8. The read also sets bit 11 of register 0.
- R5: After a panel read, no further bus request is made and no word is taken until bit 9 or bit 10 of register 1 is 1. Software writes those two bits.
- R6: Opcode 2 takes frame_bytes bytes from the pixel stream and issues each one as a bus write with bus_a0=1. With frame_bytes=0 it takes no pixel.
- R7: Opcode 3 blocks the list until a vsync pulse arrives, or until a write of 1 in bit 0 to register 2.
- R8: A write to register 2 while no vertical-sync wait is pending has no effect. A write of 0 in bit 0 releases nothing.
- R9: Opcode 5 sets bit 12 of register 0. The bit stays set until a 1 is written to bit 12 at address 0. Writing 0 leaves it set, and bit 11 clears the same way.
- R10: Opcode 4 and the unused opcodes 6 and 7 make no bus request and let the list advance.
- R11: While bus_req is high without bus_ack, bus_req, bus_rd, bus_a0 and bus_wdata stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a list when the sequencer is idle |
| list_bytes | input | 16 | List length in bytes, taken with start |
| frame_bytes | input | 16 | Pixel count for a frame-write command |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word accepted this cycle when valid |
| cmd_data | input | 32 | Two commands, lower halfword first |
| pix_valid | input | 1 | Pixel byte offered |
| pix_ready | output | 1 | Pixel byte accepted this cycle when valid |
| pix_data | input | 8 | Pixel byte |
| bus_req | output | 1 | Panel bus transfer request |
| bus_rd | output | 1 | 1 for a read transfer, 0 for a write |
| bus_a0 | output | 1 | Command/data select for the transfer |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | Transfer completes this cycle |
| bus_rdata | input | 8 | Read byte, valid with bus_ack |
| vsync | input | 1 | Vertical sync pulse from the panel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| busy | output | 1 | A list is being run |
| done | output | 1 | One-cycle pulse at list end |

## Verification
A bus transfer takes effect in the cycle in which bus_ack is high. Register effects of a read or interrupt command are visible the cycle after that command completes, and done follows the last command by one cycle. The model bus slave acknowledges after a varying delay. At the moment it raises bus_ack it compares the request fields with the head of a queue of expected transfers, so no check depends on how many cycles the engine took. Stalls are checked by waiting well past any transfer latency and confirming that the expected transfer is still queued and nothing is requested. Register contents are read at falling edges after the stalling or completing event.

// File: rtl/smart_seq_pkg.sv
// Shared types and constants for the smart panel command sequencer.
// Assumes a 16-bit command layout: opcode [11:9], select flag [8], payload [7:0].
package smart_seq_pkg;

    localparam int CMD_W   = 16;
    localparam int OP_LSB  = 9;
    localparam int A0_BIT  = 8;

    // Opcode values of the command layout
    localparam logic [2:0] OP_READ  = 3'd0;
    localparam logic [2:0] OP_WRITE = 3'd1;
    localparam logic [2:0] OP_FRAME = 3'd2;
    localparam logic [2:0] OP_VSYNC = 3'd3;
    localparam logic [2:0] OP_NOP   = 3'd4;
    localparam logic [2:0] OP_IRQ   = 3'd5;

    // Register word addresses
    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_PREAD  = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

    // Bit positions inside the registers
    localparam int ST_RDST_BIT  = 11;
    localparam int ST_CINT_BIT  = 12;
    localparam int PR_A0_BIT    = 8;
    localparam int PR_OK_BIT    = 9;
    localparam int PR_NEXT_BIT  = 10;

    typedef enum logic [2:0] {
        K_READ, K_WRITE, K_FRAME, K_VSYNC, K_IRQ, K_NOP
    } cmd_kind_t;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_EXEC, S_BUS, S_RDWAIT, S_VWAIT, S_PIX, S_PBUS
    } seq_state_t;

endpackage

// File: rtl/smart_seq_decode.sv
// Command decoder: splits one 16-bit command into its action kind, select
// flag and payload. Unused opcodes decode to a no-op. Purely combinational.
module smart_seq_decode
    import smart_seq_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output cmd_kind_t        kind,
    output logic             a0,
    output logic [7:0]       payload
);
    logic [2:0] op;

    // Pull the fields out of the command word
    always_comb begin
        op      = cmd[OP_LSB +: 3];
        a0      = cmd[A0_BIT];
        payload = cmd[7:0];
    end

    // Map the opcode to an action, unknown values become no-ops
    always_comb begin
        case (op)
            OP_READ:  kind = K_READ;
            OP_WRITE: kind = K_WRITE;
            OP_FRAME: kind = K_FRAME;
            OP_VSYNC: kind = K_VSYNC;
            OP_IRQ:   kind = K_IRQ;
            OP_NOP:   kind = K_NOP;
            default:  kind = K_NOP;
        endcase
    end

    logic unused_cmd;
    assign unused_cmd = ^cmd[CMD_W-1:OP_LSB+3];
endmodule

// File: rtl/smart_seq_regs.sv
// Software-visible registers: sticky status (write 1 to clear), panel read
// result with release flags, and the command control strobe. Assumes
// hardware set events win over a same-cycle software clear.
module smart_seq_regs
    import smart_seq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rd_capture,
    input  logic [7:0]        rd_byte,
    input  logic              rd_a0,
    input  logic              int_set,
    output logic              resume_ok,
    output logic              stop_req
);
    logic       rd_st_q, cint_q;
    logic [7:0] pdata_q;
    logic       pa0_q, ok_q, next_q;

    logic wr_status, wr_pread, wr_ctrl;
    logic clr_rdst, clr_cint;

    // Decode register write strobes
    always_comb begin
        wr_status = reg_wr && (reg_addr == ADDR_W'(ADDR_STATUS));
        wr_pread  = reg_wr && (reg_addr == ADDR_W'(ADDR_PREAD));
        wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
        clr_rdst  = wr_status && reg_wdata[ST_RDST_BIT];
        clr_cint  = wr_status && reg_wdata[ST_CINT_BIT];
        stop_req  = wr_ctrl && reg_wdata[0];
        resume_ok = ok_q || next_q;
    end

    // Sticky status bits, set by events and cleared by writing 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_st_q <= 1'b0;
            cint_q  <= 1'b0;
        end else begin
            if (rd_capture)    rd_st_q <= 1'b1;
            else if (clr_rdst) rd_st_q <= 1'b0;
            if (int_set)       cint_q  <= 1'b1;
            else if (clr_cint) cint_q  <= 1'b0;
        end
    end

    // Panel read result and software release flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdata_q <= '0;
            pa0_q   <= 1'b0;
            ok_q    <= 1'b0;
            next_q  <= 1'b0;
        end else begin
            if (rd_capture) begin
                pdata_q <= rd_byte;
                pa0_q   <= rd_a0;
            end
            if (wr_pread) begin
                ok_q   <= reg_wdata[PR_OK_BIT];
                next_q <= reg_wdata[PR_NEXT_BIT];
            end
        end
    end

    // Read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_STATUS)) begin
            reg_rdata[ST_RDST_BIT] = rd_st_q;
            reg_rdata[ST_CINT_BIT] = cint_q;
        end else if (reg_addr == ADDR_W'(ADDR_PREAD)) begin
            reg_rdata[7:0]         = pdata_q;
            reg_rdata[PR_A0_BIT]   = pa0_q;
            reg_rdata[PR_OK_BIT]   = ok_q;
            reg_rdata[PR_NEXT_BIT] = next_q;
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[DATA_W-1:ST_CINT_BIT+1], reg_wdata[8:1]};

    // Interrupt status persists until a clearing write
    assert_int_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cint_q && !clr_cint) |=> cint_q);

    // Read data only changes when a panel read completes
    assert_pread_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_capture |=> $stable(pdata_q) && $stable(pa0_q));
endmodule

// File: rtl/smart_seq_fsm.sv
// Sequencer control: fetches packed command words, runs each halfword in
// order, and drives the bus request, pixel stream and register events.
// Assumes list_bytes is even; a remainder of 2 or fewer bytes ends the list.
module smart_seq_fsm
    import smart_seq_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int FRM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] list_bytes,
    input  logic [FRM_W-1:0] frame_bytes,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2*CMD_W-1:0] cmd_data,
    input  logic             pix_valid,
    output logic             pix_ready,
    input  logic [7:0]       pix_data,
    output logic             bus_req,
    output logic             bus_rd,
    output logic             bus_a0,
    output logic [7:0]       bus_wdata,
    input  logic             bus_ack,
    input  logic [7:0]       bus_rdata,
    input  logic             vsync,
    input  logic             stop_req,
    input  logic             resume_ok,
    output logic             rd_capture,
    output logic [7:0]       rd_byte,
    output logic             rd_a0,
    output logic             int_set,
    output logic             busy,
    output logic             done
);
    localparam logic [LEN_W-1:0] STEP = LEN_W'(2);

    seq_state_t         state_q, state_n;
    logic [2*CMD_W-1:0] word_q;
    logic               upper_q;
    logic [LEN_W-1:0]   rem_q;
    logic [FRM_W-1:0]   fcnt_q;
    logic [7:0]         pbyte_q;

    logic [CMD_W-1:0] cur_cmd;
    cmd_kind_t        kind;
    logic             cur_a0;
    logic [7:0]       cur_pay;
    logic             fin, last;

    // Select the halfword under execution
    assign cur_cmd = upper_q ? word_q[2*CMD_W-1:CMD_W] : word_q[CMD_W-1:0];

    smart_seq_decode u_dec (
        .cmd     (cur_cmd),
        .kind    (kind),
        .a0      (cur_a0),
        .payload (cur_pay)
    );

    // Next state, handshakes and the per-command finish flag
    always_comb begin
        state_n   = state_q;
        fin       = 1'b0;
        cmd_ready = 1'b0;
        pix_ready = 1'b0;
        bus_req   = 1'b0;
        bus_rd    = 1'b0;
        bus_a0    = 1'b0;
        bus_wdata = '0;
        case (state_q)
            S_IDLE:
                if (start && list_bytes != '0) state_n = S_FETCH;
            S_FETCH: begin
                cmd_ready = 1'b1;
                if (cmd_valid) state_n = S_EXEC;
            end
            S_EXEC:
                case (kind)
                    K_READ, K_WRITE: state_n = S_BUS;
                    K_FRAME:
                        if (frame_bytes == '0) fin = 1'b1;
                        else                   state_n = S_PIX;
                    K_VSYNC: state_n = S_VWAIT;
                    default: fin = 1'b1;
                endcase
            S_BUS: begin
                bus_req   = 1'b1;
                bus_rd    = (kind == K_READ);
                bus_a0    = cur_a0;
                bus_wdata = cur_pay;
                if (bus_ack) begin
                    if (kind == K_READ) state_n = S_RDWAIT;
                    else                fin = 1'b1;
                end
            end
            S_RDWAIT:
                if (resume_ok) fin = 1'b1;
            S_VWAIT:
                if (vsync || stop_req) fin = 1'b1;
            S_PIX: begin
                pix_ready = 1'b1;
                if (pix_valid) state_n = S_PBUS;
            end
            S_PBUS: begin
                bus_req   = 1'b1;
                bus_a0    = 1'b1;
                bus_wdata = pbyte_q;
                if (bus_ack) begin
                    if (fcnt_q == FRM_W'(1)) fin = 1'b1;
                    else                     state_n = S_PIX;
                end
            end
            default: state_n = S_IDLE;
        endcase
        last = (rem_q <= STEP);
        if (fin) begin
            if (last)         state_n = S_IDLE;
            else if (upper_q) state_n = S_FETCH;
            else              state_n = S_EXEC;
        end
    end

    // Events handed to the register block
    always_comb begin
        rd_capture = (state_q == S_BUS) && bus_ack && (kind == K_READ);
        rd_byte    = bus_rdata;
        rd_a0      = cur_a0;
        int_set    = (state_q == S_EXEC) && (kind == K_IRQ);
        busy       = (state_q != S_IDLE);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // List bookkeeping: remaining bytes, current word, half select, done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            word_q  <= '0;
            upper_q <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == S_IDLE && start) begin
                rem_q <= list_bytes;
                if (list_bytes == '0) done <= 1'b1;
            end
            if (state_q == S_FETCH && cmd_valid) begin
                word_q  <= cmd_data;
                upper_q <= 1'b0;
            end
            if (fin) begin
                rem_q <= last ? '0 : rem_q - STEP;
                if (last)          done    <= 1'b1;
                else if (!upper_q) upper_q <= 1'b1;
            end
        end
    end

    // Frame pixel counter and holding byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt_q  <= '0;
            pbyte_q <= '0;
        end else begin
            if (state_q == S_EXEC && kind == K_FRAME) fcnt_q <= frame_bytes;
            if (state_q == S_PIX && pix_valid)        pbyte_q <= pix_data;
            if (state_q == S_PBUS && bus_ack)         fcnt_q <= fcnt_q - FRM_W'(1);
        end
    end

    // Request fields hold while the engine has not acknowledged
    assert_req_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req && $stable(bus_rd) && $stable(bus_a0)
                                  && $stable(bus_wdata));

    // At most one of fetch, pixel intake and bus request at a time
    assert_one_stream_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ready, pix_ready, bus_req}));

    // Done only pulses with the sequencer idle, and for one cycle
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // No activity while a read waits for release
    assert_read_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RDWAIT && !resume_ok) |=> !bus_req && !cmd_ready);
endmodule

// File: rtl/smart_cmd_seq.sv
// Top of the smart panel command sequencer: joins the control sequencer with
// the register block. Assumes a single clock and synchronous active-low reset.
module smart_cmd_seq #(
    parameter int LEN_W  = 16,
    parameter int FRM_W  = 16,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  list_bytes,
    input  logic [FRM_W-1:0]  frame_bytes,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [31:0]       cmd_data,
    input  logic              pix_valid,
    output logic              pix_ready,
    input  logic [7:0]        pix_data,
    output logic              bus_req,
    output logic              bus_rd,
    output logic              bus_a0,
    output logic [7:0]        bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    input  logic              vsync,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              busy,
    output logic              done
);
    logic       resume_ok, stop_req, rd_capture, rd_a0, int_set;
    logic [7:0] rd_byte;

    smart_seq_fsm #(.LEN_W(LEN_W), .FRM_W(FRM_W)) u_fsm (
        .clk (clk), .rst_n (rst_n), .start (start),
        .list_bytes (list_bytes), .frame_bytes (frame_bytes),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_data (cmd_data),
        .pix_valid (pix_valid), .pix_ready (pix_ready), .pix_data (pix_data),
        .bus_req (bus_req), .bus_rd (bus_rd), .bus_a0 (bus_a0),
        .bus_wdata (bus_wdata), .bus_ack (bus_ack), .bus_rdata (bus_rdata),
        .vsync (vsync), .stop_req (stop_req), .resume_ok (resume_ok),
        .rd_capture (rd_capture), .rd_byte (rd_byte), .rd_a0 (rd_a0),
        .int_set (int_set), .busy (busy), .done (done)
    );

    smart_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .rd_capture (rd_capture), .rd_byte (rd_byte), .rd_a0 (rd_a0),
        .int_set (int_set), .resume_ok (resume_ok), .stop_req (stop_req)
    );
endmodule

// File: tb/smart_cmd_seq_tb_top.sv
// Scoreboard bench: tasks queue expected bus transfers, the model bus slave
// compares each request against the queue head when it acknowledges.
module smart_cmd_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] list_bytes = '0;
    logic [15:0] frame_bytes = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_data = '0;
    logic        pix_valid = 1'b0;
    logic        pix_ready;
    logic [7:0]  pix_data = '0;
    logic        bus_req, bus_rd, bus_a0;
    logic [7:0]  bus_wdata;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata = '0;
    logic        vsync = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, done;

    int n_checks = 0;
    int n_fails = 0;
    int done_cnt = 0;
    int ack_wait = 0;
    int n_acks = 0;
    bit finished = 0;
    logic [7:0] rd_val = 8'h00;
    logic [9:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    smart_cmd_seq dut_i (
        .clk (clk), .rst_n (rst_n), .start (start), .list_bytes (list_bytes),
        .frame_bytes (frame_bytes), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
        .cmd_data (cmd_data), .pix_valid (pix_valid), .pix_ready (pix_ready),
        .pix_data (pix_data), .bus_req (bus_req), .bus_rd (bus_rd),
        .bus_a0 (bus_a0), .bus_wdata (bus_wdata), .bus_ack (bus_ack),
        .bus_rdata (bus_rdata), .vsync (vsync), .reg_wr (reg_wr),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .busy (busy), .done (done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model bus slave and transfer monitor
    always @(negedge clk) begin
        if (done) done_cnt++;
        if (bus_ack) begin
            bus_ack = 1'b0;
            ack_wait = 0;
        end else if (bus_req && rst_n) begin
            if (ack_wait >= (n_acks % 3)) begin
                logic [9:0] got;
                got = {bus_rd, bus_a0, bus_wdata};
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected transfer", {22'b0, got}, 32'h0);
                end else begin
                    logic [9:0] want;
                    want = exp_q.pop_front();
                    check(got == want, "R1/R4/R6 transfer", {22'b0, got}, {22'b0, want});
                end
                bus_rdata = rd_val;
                bus_ack = 1'b1;
                n_acks++;
            end else begin
                ack_wait++;
            end
        end
    end

    task automatic expect_xfer(input bit rd, input bit a0, input logic [7:0] d);
        exp_q.push_back({rd, a0, d});
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic start_list(input logic [15:0] len);
        done_cnt = 0;
        start = 1'b1; list_bytes = len;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        cmd_valid = 1'b1; cmd_data = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_pix(input logic [7:0] b);
        pix_valid = 1'b1; pix_data = b;
        while (!pix_ready) @(negedge clk);
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (done_cnt == 0 && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(done_cnt == 1, tag, done_cnt, 1);
        @(negedge clk);
        check(!busy && exp_q.size() == 0, {tag, " idle and queue drained"},
              {busy, 31'(exp_q.size())}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        reg_read(2'd0, r); check(r == 0, "R9 status after reset", r, 0);
        reg_read(2'd1, r); check(r == 0, "R4 read register after reset", r, 0);
        check(!busy && !done && !cmd_ready && !bus_req, "R3 idle after reset",
              {busy, done, cmd_ready, bus_req}, 0);

        // R1 R2 R10: writes in halfword order, no-op and unused opcodes skipped
        expect_xfer(0, 0, 8'h2A);
        expect_xfer(0, 1, 8'h55);
        expect_xfer(0, 1, 8'h11);
        start_list(16'd12);
        send_word({16'h0355, 16'h022A});
        send_word({16'h0E00, 16'h0800});
        send_word({16'h0311, 16'h0C00});
        wait_done("R2 three-word list done");

        // R2: list of one command runs only the lower half
        expect_xfer(0, 0, 8'h44);
        start_list(16'd2);
        send_word({16'h0399, 16'h0244});
        wait_done("R2 single command done");
        repeat (5) @(negedge clk);
        check(!cmd_ready && !bus_req, "R2 no further fetch", {cmd_ready, bus_req}, 0);

        // R3: zero-length list
        start_list(16'd0);
        check(done && !cmd_ready, "R3 zero length done next cycle", {done, cmd_ready}, 32'h2);
        @(negedge clk);
        check(!done && !busy, "R3 done one cycle", {done, busy}, 0);

        // R4 R5: frame-memory read stalls until continue-to-next flag
        reg_write(2'd1, 32'h0);
        rd_val = 8'hA5;
        expect_xfer(1, 1, 8'h00);
        expect_xfer(0, 0, 8'h33);
        start_list(16'd4);
        send_word({16'h0233, 16'h0100});
        repeat (20) @(negedge clk);
        check(exp_q.size() == 1 && !bus_req, "R5 stalled after read",
              {bus_req, 31'(exp_q.size())}, 1);
        reg_read(2'd1, r); check(r == 32'h1A5, "R4 read byte and select", r, 32'h1A5);
        reg_read(2'd0, r); check(r == 32'h800, "R4 read status bit", r, 32'h800);
        reg_write(2'd1, 32'h400);
        wait_done("R5 resume on continue flag");
        reg_write(2'd0, 32'h800);
        reg_read(2'd0, r); check(r == 0, "R9 read status cleared", r, 0);

        // R4 R5: status-register read released by status-OK flag
        reg_write(2'd1, 32'h0);
        rd_val = 8'h3C;
        expect_xfer(1, 0, 8'h00);
        expect_xfer(0, 1, 8'h66);
        start_list(16'd4);
        send_word({16'h0366, 16'h0000});
        repeat (15) @(negedge clk);
        check(exp_q.size() == 1, "R5 stalled before OK flag", exp_q.size(), 1);
        reg_read(2'd1, r); check(r == 32'h03C, "R4 status read byte", r, 32'h03C);
        reg_write(2'd1, 32'h200);
        wait_done("R5 resume on OK flag");
        reg_write(2'd1, 32'h0);
        reg_write(2'd0, 32'h800);

        // R6: frame write of three pixels then a data write
        frame_bytes = 16'd3;
        expect_xfer(0, 1, 8'h10);
        expect_xfer(0, 1, 8'h20);
        expect_xfer(0, 1, 8'h30);
        expect_xfer(0, 1, 8'h01);
        start_list(16'd4);
        send_word({16'h0301, 16'h0500});
        send_pix(8'h10);
        send_pix(8'h20);
        send_pix(8'h30);
        wait_done("R6 frame of three pixels");

        // R6: zero pixel count takes no pixel
        frame_bytes = 16'd0;
        expect_xfer(0, 1, 8'h02);
        start_list(16'd4);
        send_word({16'h0302, 16'h0500});
        wait_done("R6 empty frame");

        // R7 R8: vsync wait, stray control writes ignored, released by vsync
        reg_write(2'd2, 32'h1);
        expect_xfer(0, 1, 8'hAA);
        start_list(16'd4);
        send_word({16'h03AA, 16'h0600});
        repeat (10) @(negedge clk);
        check(exp_q.size() == 1 && busy, "R8 early stop write ignored",
              {busy, 31'(exp_q.size())}, 32'h8000_0001);
        reg_write(2'd2, 32'h0);
        repeat (5) @(negedge clk);
        check(exp_q.size() == 1, "R8 zero control write ignored", exp_q.size(), 1);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        wait_done("R7 released by vsync");

        // R7: forced release through command control
        expect_xfer(0, 1, 8'hBB);
        start_list(16'd4);
        send_word({16'h03BB, 16'h0600});
        repeat (8) @(negedge clk);
        check(exp_q.size() == 1, "R7 waiting for sync", exp_q.size(), 1);
        reg_write(2'd2, 32'h1);
        wait_done("R7 released by control write");

        // R9 R10: interrupt opcode then no-op, sticky bit
        start_list(16'd4);
        send_word({16'h0800, 16'h0A00});
        wait_done("R10 interrupt list done");
        reg_read(2'd0, r); check(r == 32'h1000, "R9 interrupt bit set", r, 32'h1000);
        reg_write(2'd0, 32'h0);
        reg_read(2'd0, r); check(r == 32'h1000, "R9 zero write keeps bit", r, 32'h1000);
        reg_write(2'd0, 32'h1000);
        reg_read(2'd0, r); check(r == 0, "R9 one write clears bit", r, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule